// File: doc/BRIEF.md
# DAC Register Reset and Shadow Controller

This block owns the register file of a small serially controlled DAC. It keeps a working (volatile) copy and a persistent (nonvolatile) copy of the DAC code and of five configuration bits: a 2-bit reference select, a 2-bit power-down field and a gain bit. It also keeps two status bits that exist only in the working copy: a ready flag and a supply-good flag. The serial bit engine in front of it hands over decoded command strobes with their data and an acknowledge strobe. The block decides which commands are accepted. It applies the supply-related and bus-issued resets. It also runs the timed write cycle of the persistent copy, which is modelled as plain registers with a fixed cycle length in clocks.

The supply-related resets arrive as two synchronous level inputs. The power-on input reloads the working copy from the persistent copy and arms a delay timer that blocks all commands. The brown-out input parks the output in power-down and takes priority over power-on. A general-call reset performs the same reload as power-on without arming the timer. A write-all command updates the working copy at once. Its persistent write begins at the next acknowledge and keeps the ready flag low until it completes. While the ready flag is low, only reads are accepted.

Top module: `dac_shadow_ctrl`

## Requirements
- R1: In every cycle that follows a clock edge with `bor_i` high, `vol_pd_o` is 2'b11, `vol_code_o`, `vol_vref_o` and `vol_gain_o` are 0, and `stat_por_o` is 0. While `bor_i` is high, `stat_rdy_o` is 0. Synchronous `rst` leaves the working copy in this same state, with `stat_rdy_o` at 1 and the persistent copy at the factory parameters.
- R2: When `bor_i` and `por_i` are both high at an edge, the brown-out state of R1 wins over the reload.
- R3: An edge with `por_i` high copies the persistent code and configuration into the working copy.
- R4: After `por_i` falls, no command, not even a read, is accepted in the first POR_DELAY cycles. The first command can be accepted in the cycle after those.
- R5: An accepted general-call reset reloads the working copy from the persistent copy at the next edge, and does not block commands in the following cycle.
- R6: An accepted volatile write updates only the working code and configuration. The persistent copy is left unchanged.
- R7: An accepted write-all updates the working copy at the next edge. The persistent copy takes the same values only at the end of the write cycle started by the acknowledge. Before that end, the persistent copy never changes.
- R8: An `ack_i` with a write-all pending (or accepted in the same cycle) drives `stat_rdy_o` low from the next edge for exactly NV_WR_CYCLES cycles. An active `por_i` or `bor_i` cancels the write and the pending data.
- R9: While `stat_rdy_o` is low, volatile write, write-all and general-call strobes are refused and have no effect. Reads are still accepted.
- R10: `stat_por_o` is 0 in the cycle after an edge with `por_i` or `bor_i` high, and 1 after an edge with both low.
- R11: `cmd_accept_o` is 0 in any cycle where `por_i` or `bor_i` is high.
- R12: When several command strobes are high together, only one is served, in this order: general-call reset, write-all, volatile write, read. `cmd_accept_o` reflects the served one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Power-on reset level, synchronous |
| bor_i | input | 1 | Brown-out level, synchronous |
| cmd_vol_wr_i | input | 1 | Volatile write command strobe |
| cmd_all_wr_i | input | 1 | Write-all command strobe |
| cmd_rd_i | input | 1 | Read command strobe |
| cmd_gc_rst_i | input | 1 | General-call reset strobe |
| wr_code_i | input | CODE_W | DAC code for write commands |
| wr_vref_i | input | 2 | Reference select for write commands |
| wr_pd_i | input | 2 | Power-down field for write commands |
| wr_gain_i | input | 1 | Gain bit for write commands |
| ack_i | input | 1 | Acknowledge strobe that starts a persistent write |
| vol_code_o | output | CODE_W | Working DAC code |
| vol_vref_o | output | 2 | Working reference select |
| vol_pd_o | output | 2 | Working power-down field |
| vol_gain_o | output | 1 | Working gain bit |
| stat_rdy_o | output | 1 | Ready flag, low during a persistent write or brown-out |
| stat_por_o | output | 1 | Supply-good flag |
| cmd_accept_o | output | 1 | A strobe in this cycle is accepted |

## Verification
The assertions check these on every cycle: the brown-out forced state, the blocking of acceptance under either supply reset, refusal of writes while busy, the supply-good flag tracking its inputs, and that the persistent copy moves only when the ready flag rises. The bench's scenarios must show the rest. These include the exact length of the power-on blackout and of the busy window, that a volatile write leaves the persistent copy alone (seen through a later reload), the strobe priority, and that write-all data really lands in the persistent copy. A reference model in the bench follows every random cycle to catch mismatches in values, not only in protocol.

// File: rtl/dac_shadow_pkg.sv
`timescale 1ns/1ps
package dac_shadow_pkg;

    typedef struct packed {
        logic [1:0] vref;
        logic [1:0] pd;
        logic       gain;
    } cfg_t;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_READ  = 3'd1,
        CMD_VOLWR = 3'd2,
        CMD_ALLWR = 3'd3,
        CMD_GCRST = 3'd4
    } cmd_e;

    localparam logic [1:0] PD_PARKED = 2'b11;

    // Configuration forced by a brown-out: output parked, all else cleared
    function automatic cfg_t parked_cfg();
        cfg_t c;
        c.vref = 2'b00;
        c.pd   = PD_PARKED;
        c.gain = 1'b0;
        return c;
    endfunction

    function automatic bit code_width_ok(int unsigned w);
        return (w == 8) || (w == 10) || (w == 12);
    endfunction

    // Serve at most one strobe; fixed priority gc > all > vol > read
    function automatic cmd_e pick_cmd(logic gc, logic all, logic vol, logic rd);
        if (gc)       return CMD_GCRST;
        else if (all) return CMD_ALLWR;
        else if (vol) return CMD_VOLWR;
        else if (rd)  return CMD_READ;
        else          return CMD_NONE;
    endfunction

endpackage

// File: rtl/dac_cmd_arbiter.sv
`timescale 1ns/1ps
module dac_cmd_arbiter
    import dac_shadow_pkg::*;
(
    input  logic gc_i,
    input  logic all_i,
    input  logic vol_i,
    input  logic rd_i,
    input  logic hold_i,
    input  logic ready_i,
    output cmd_e sel_o,
    output logic accept_o
);

    cmd_e sel;

    always_comb begin
        sel      = pick_cmd(gc_i, all_i, vol_i, rd_i);
        accept_o = 1'b0;
        if (!hold_i) begin
            unique case (sel)
                CMD_READ:                         accept_o = 1'b1;
                CMD_VOLWR, CMD_ALLWR, CMD_GCRST:  accept_o = ready_i;
                default:                          accept_o = 1'b0;
            endcase
        end
    end

    assign sel_o = sel;

endmodule

// File: rtl/dac_por_timer.sv
`timescale 1ns/1ps
module dac_por_timer #(
    parameter int unsigned POR_DELAY = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic por_i,
    input  logic bor_i,
    output logic hold_o,
    output logic supply_ok_o
);

    localparam int unsigned TW = $clog2(POR_DELAY + 1);

    logic [TW-1:0] remain;
    logic          ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= TW'(POR_DELAY);
            ok_q   <= 1'b0;
        end else begin
            if (por_i)
                remain <= TW'(POR_DELAY);
            else if (remain != '0)
                remain <= remain - 1'b1;
            ok_q <= !(por_i || bor_i);
        end
    end

    assign hold_o      = (remain != '0);
    assign supply_ok_o = ok_q;

endmodule

// File: rtl/dac_nv_store.sv
`timescale 1ns/1ps
module dac_nv_store
    import dac_shadow_pkg::*;
#(
    parameter int unsigned CODE_W       = 8,
    parameter int unsigned NV_WR_CYCLES = 24,
    parameter int unsigned FACT_CODE    = 128,
    parameter logic [4:0]  FACT_CFG     = 5'b00000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort_i,
    input  logic              load_i,
    input  logic [CODE_W-1:0] load_code_i,
    input  cfg_t              load_cfg_i,
    input  logic              ack_i,
    output logic [CODE_W-1:0] nv_code_o,
    output cfg_t              nv_cfg_o,
    output logic              ready_o
);

    localparam int unsigned CW = $clog2(NV_WR_CYCLES + 1);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        cfg_t              cfg;
    } word_t;

    word_t          cells;
    word_t          staged;
    logic           pending;
    logic           ready;
    logic [CW-1:0]  left;
    logic           start;

    assign start = ready && ack_i && (pending || load_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cells.code <= CODE_W'(FACT_CODE);
            cells.cfg  <= cfg_t'(FACT_CFG);
            staged     <= '0;
            pending    <= 1'b0;
            ready      <= 1'b1;
            left       <= '0;
        end else if (abort_i) begin
            pending <= 1'b0;
            ready   <= 1'b1;
            left    <= '0;
        end else if (!ready) begin
            if (left != '0) begin
                left <= left - 1'b1;
            end else begin
                cells <= staged;
                ready <= 1'b1;
            end
        end else begin
            if (load_i) begin
                staged.code <= load_code_i;
                staged.cfg  <= load_cfg_i;
                pending     <= 1'b1;
            end
            if (start) begin
                ready   <= 1'b0;
                left    <= CW'(NV_WR_CYCLES - 1);
                pending <= 1'b0;
            end
        end
    end

    assign nv_code_o = cells.code;
    assign nv_cfg_o  = cells.cfg;
    assign ready_o   = ready;

endmodule

// File: rtl/dac_vol_regs.sv
`timescale 1ns/1ps
module dac_vol_regs
    import dac_shadow_pkg::*;
#(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bor_i,
    input  logic              por_i,
    input  logic              reload_i,
    input  logic              write_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  cfg_t              wr_cfg_i,
    input  logic [CODE_W-1:0] nv_code_i,
    input  cfg_t              nv_cfg_i,
    output logic [CODE_W-1:0] code_o,
    output cfg_t              cfg_o
);

    logic [CODE_W-1:0] code_q;
    cfg_t              cfg_q;

    always_ff @(posedge clk) begin
        if (rst || bor_i) begin
            code_q <= '0;
            cfg_q  <= parked_cfg();
        end else if (por_i || reload_i) begin
            code_q <= nv_code_i;
            cfg_q  <= nv_cfg_i;
        end else if (write_i) begin
            code_q <= wr_code_i;
            cfg_q  <= wr_cfg_i;
        end
    end

    assign code_o = code_q;
    assign cfg_o  = cfg_q;

endmodule

// File: rtl/dac_shadow_ctrl.sv
`timescale 1ns/1ps
module dac_shadow_ctrl
    import dac_shadow_pkg::*;
#(
    parameter int unsigned CODE_W       = 8,
    parameter int unsigned POR_DELAY    = 16,
    parameter int unsigned NV_WR_CYCLES = 24,
    parameter int unsigned FACT_CODE    = 128,
    parameter logic [4:0]  FACT_CFG     = 5'b00000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_i,
    input  logic              bor_i,
    input  logic              cmd_vol_wr_i,
    input  logic              cmd_all_wr_i,
    input  logic              cmd_rd_i,
    input  logic              cmd_gc_rst_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic [1:0]        wr_vref_i,
    input  logic [1:0]        wr_pd_i,
    input  logic              wr_gain_i,
    input  logic              ack_i,
    output logic [CODE_W-1:0] vol_code_o,
    output logic [1:0]        vol_vref_o,
    output logic [1:0]        vol_pd_o,
    output logic              vol_gain_o,
    output logic              stat_rdy_o,
    output logic              stat_por_o,
    output logic              cmd_accept_o
);

    if (!code_width_ok(CODE_W)) begin : g_bad_width
        $error("dac_shadow_ctrl: CODE_W must be 8, 10 or 12");
    end

    cfg_t              wr_cfg;
    cfg_t              nv_cfg;
    cfg_t              vol_cfg;
    logic [CODE_W-1:0] nv_code;
    logic              nv_ready;
    logic              timer_hold;
    logic              supply_ok;
    logic              hold;
    cmd_e              sel;
    logic              accept;
    logic              do_reload;
    logic              do_write;
    logic              do_all;

    assign wr_cfg.vref = wr_vref_i;
    assign wr_cfg.pd   = wr_pd_i;
    assign wr_cfg.gain = wr_gain_i;

    assign hold      = por_i || bor_i || timer_hold;
    assign do_reload = accept && (sel == CMD_GCRST);
    assign do_all    = accept && (sel == CMD_ALLWR);
    assign do_write  = accept && ((sel == CMD_ALLWR) || (sel == CMD_VOLWR));

    dac_por_timer #(
        .POR_DELAY   (POR_DELAY)
    ) timer_i (
        .clk         (clk),
        .rst         (rst),
        .por_i       (por_i),
        .bor_i       (bor_i),
        .hold_o      (timer_hold),
        .supply_ok_o (supply_ok)
    );

    dac_cmd_arbiter arb_i (
        .gc_i     (cmd_gc_rst_i),
        .all_i    (cmd_all_wr_i),
        .vol_i    (cmd_vol_wr_i),
        .rd_i     (cmd_rd_i),
        .hold_i   (hold),
        .ready_i  (nv_ready),
        .sel_o    (sel),
        .accept_o (accept)
    );

    dac_nv_store #(
        .CODE_W       (CODE_W),
        .NV_WR_CYCLES (NV_WR_CYCLES),
        .FACT_CODE    (FACT_CODE),
        .FACT_CFG     (FACT_CFG)
    ) nv_i (
        .clk         (clk),
        .rst         (rst),
        .abort_i     (por_i || bor_i),
        .load_i      (do_all),
        .load_code_i (wr_code_i),
        .load_cfg_i  (wr_cfg),
        .ack_i       (ack_i),
        .nv_code_o   (nv_code),
        .nv_cfg_o    (nv_cfg),
        .ready_o     (nv_ready)
    );

    dac_vol_regs #(
        .CODE_W    (CODE_W)
    ) vol_i (
        .clk       (clk),
        .rst       (rst),
        .bor_i     (bor_i),
        .por_i     (por_i),
        .reload_i  (do_reload),
        .write_i   (do_write),
        .wr_code_i (wr_code_i),
        .wr_cfg_i  (wr_cfg),
        .nv_code_i (nv_code),
        .nv_cfg_i  (nv_cfg),
        .code_o    (vol_code_o),
        .cfg_o     (vol_cfg)
    );

    assign vol_vref_o   = vol_cfg.vref;
    assign vol_pd_o     = vol_cfg.pd;
    assign vol_gain_o   = vol_cfg.gain;
    assign stat_rdy_o   = nv_ready && !bor_i;
    assign stat_por_o   = supply_ok;
    assign cmd_accept_o = accept;

endmodule

// File: rtl/dac_shadow_chk.sv
`timescale 1ns/1ps
module dac_shadow_chk #(
    parameter int unsigned CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              por_i,
    input logic              bor_i,
    input logic              cmd_vol_wr_i,
    input logic              cmd_all_wr_i,
    input logic              cmd_gc_rst_i,
    input logic              ack_i,
    input logic [CODE_W-1:0] vol_code_o,
    input logic [1:0]        vol_vref_o,
    input logic [1:0]        vol_pd_o,
    input logic              vol_gain_o,
    input logic              stat_rdy_o,
    input logic              stat_por_o,
    input logic              cmd_accept_o,
    input logic [CODE_W-1:0] nv_code,
    input logic [4:0]        nv_cfg_bits,
    input logic              nv_ready
);

    a_r1_bor_parks_output: assert property (@(posedge clk) disable iff (rst)
        bor_i |=> (vol_pd_o == 2'b11) && (vol_code_o == '0) && (vol_vref_o == 2'b00)
                  && !vol_gain_o && !stat_por_o);

    a_r1_bor_rdy_low: assert property (@(posedge clk) disable iff (rst)
        bor_i |-> !stat_rdy_o);

    a_r11_no_accept_in_reset: assert property (@(posedge clk) disable iff (rst)
        (por_i || bor_i) |-> !cmd_accept_o);

    a_r4_blocked_after_release: assert property (@(posedge clk) disable iff (rst)
        $fell(por_i) |-> !cmd_accept_o);

    a_r9_busy_refuses_writes: assert property (@(posedge clk) disable iff (rst)
        (!stat_rdy_o && (cmd_vol_wr_i || cmd_all_wr_i || cmd_gc_rst_i)) |-> !cmd_accept_o);

    a_r10_flag_low: assert property (@(posedge clk) disable iff (rst)
        (por_i || bor_i) |=> !stat_por_o);

    a_r10_flag_high: assert property (@(posedge clk) disable iff (rst)
        (!por_i && !bor_i) |=> stat_por_o);

    a_r7_nv_moves_at_cycle_end: assert property (@(posedge clk) disable iff (rst)
        (!$stable(nv_code) || !$stable(nv_cfg_bits)) |-> $rose(nv_ready));

    a_r8_busy_starts_on_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(nv_ready) |-> $past(ack_i));

endmodule

bind dac_shadow_ctrl dac_shadow_chk #(.CODE_W(CODE_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .por_i        (por_i),
    .bor_i        (bor_i),
    .cmd_vol_wr_i (cmd_vol_wr_i),
    .cmd_all_wr_i (cmd_all_wr_i),
    .cmd_gc_rst_i (cmd_gc_rst_i),
    .ack_i        (ack_i),
    .vol_code_o   (vol_code_o),
    .vol_vref_o   (vol_vref_o),
    .vol_pd_o     (vol_pd_o),
    .vol_gain_o   (vol_gain_o),
    .stat_rdy_o   (stat_rdy_o),
    .stat_por_o   (stat_por_o),
    .cmd_accept_o (cmd_accept_o),
    .nv_code      (nv_code),
    .nv_cfg_bits  (nv_cfg),
    .nv_ready     (nv_ready)
);

// File: tb/dac_shadow_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_shadow_ctrl_tb_top;

    localparam int unsigned W      = 10;
    localparam int unsigned PD_LEN = 6;
    localparam int unsigned WR_LEN = 9;
    localparam int unsigned F_CODE = 'h2A5;
    localparam logic [4:0]  F_CFG  = 5'b01001;
    localparam logic [4:0]  PARKED = 5'b00110;   // {vref, pd, gain}

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst, por, bor, vw, aw, rd, gc, ack;
    logic [W-1:0] wcode;
    logic [4:0]   wcfg;
    logic [W-1:0] vcode;
    logic [1:0]   vvref, vpd;
    logic         vgain, srdy, spor, acc;

    dac_shadow_ctrl #(
        .CODE_W(W), .POR_DELAY(PD_LEN), .NV_WR_CYCLES(WR_LEN),
        .FACT_CODE(F_CODE), .FACT_CFG(F_CFG)
    ) dut_i (
        .clk(clk), .rst(rst), .por_i(por), .bor_i(bor),
        .cmd_vol_wr_i(vw), .cmd_all_wr_i(aw), .cmd_rd_i(rd), .cmd_gc_rst_i(gc),
        .wr_code_i(wcode), .wr_vref_i(wcfg[4:3]), .wr_pd_i(wcfg[2:1]), .wr_gain_i(wcfg[0]),
        .ack_i(ack),
        .vol_code_o(vcode), .vol_vref_o(vvref), .vol_pd_o(vpd), .vol_gain_o(vgain),
        .stat_rdy_o(srdy), .stat_por_o(spor), .cmd_accept_o(acc)
    );

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [W-1:0] m_code, m_nvcode, m_bufcode;
    logic [4:0]   m_cfg, m_nvcfg, m_bufcfg;
    logic         m_ready, m_pend, m_porbit;
    int           m_timer, m_left;
    logic         last_acc;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_accept(logic p, logic b, logic v, logic a, logic r, logic g);
        bit gate = !p && !b && (m_timer == 0);
        if (g || a || v) return gate && m_ready;
        if (r)           return gate;
        return 1'b0;
    endfunction

    task automatic model_edge(logic p, logic b, logic v, logic a, logic g, logic k,
                              logic [W-1:0] c, logic [4:0] f, bit ok);
        bit sel_a  = !g && a;
        bit sel_v  = !g && !a && v;
        bit a_acc  = ok && sel_a;
        // working copy
        if (b) begin m_code = '0; m_cfg = PARKED; end
        else if (p || (ok && g)) begin m_code = m_nvcode; m_cfg = m_nvcfg; end
        else if (ok && (sel_a || sel_v)) begin m_code = c; m_cfg = f; end
        // timer and flag
        if (p) m_timer = PD_LEN;
        else if (m_timer > 0) m_timer--;
        m_porbit = !(p || b);
        // persistent copy
        if (p || b) begin
            m_ready = 1'b1; m_left = 0; m_pend = 1'b0;
        end else if (!m_ready) begin
            if (m_left != 0) m_left--;
            else begin m_nvcode = m_bufcode; m_nvcfg = m_bufcfg; m_ready = 1'b1; end
        end else begin
            if (a_acc) begin m_bufcode = c; m_bufcfg = f; m_pend = 1'b1; end
            if (k && (m_pend || a_acc)) begin
                m_ready = 1'b0; m_left = WR_LEN - 1; m_pend = 1'b0;
            end
        end
    endtask

    // One cycle: drive at a negedge, check accept, advance, compare at next negedge
    task automatic step(logic p, logic b, logic v, logic a, logic r, logic g, logic k,
                        logic [W-1:0] c, logic [4:0] f);
        bit e_acc;
        por = p; bor = b; vw = v; aw = a; rd = r; gc = g; ack = k; wcode = c; wcfg = f;
        #1;
        e_acc = model_accept(p, b, v, a, r, g);
        last_acc = acc;
        chk(acc == e_acc, "R4/R9/R11/R12", "accept", acc, e_acc);
        model_edge(p, b, v, a, g, k, c, f, e_acc);
        @(negedge clk);
        chk(vcode == m_code, "R1/R2/R3/R5/R6/R7", "code", vcode, m_code);
        chk({vvref, vpd, vgain} == m_cfg, "R1/R2/R3/R5/R6/R7", "cfg", {vvref, vpd, vgain}, m_cfg);
        chk(srdy == (m_ready && !b), "R8", "ready", srdy, m_ready && !b);
        chk(spor == m_porbit, "R10", "supply flag", spor, m_porbit);
    endtask

    task automatic idle(logic r);
        step(0, 0, 0, 0, r, 0, 0, '0, '0);
    endtask

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog all act=hung exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h5eed_0d1a));
        rst = 1'b1; por = 0; bor = 0; vw = 0; aw = 0; rd = 0; gc = 0; ack = 0;
        wcode = '0; wcfg = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_code = '0; m_cfg = PARKED; m_nvcode = W'(F_CODE); m_nvcfg = F_CFG;
        m_bufcode = '0; m_bufcfg = '0; m_ready = 1; m_pend = 0; m_porbit = 0;
        m_timer = PD_LEN; m_left = 0;
        // reset state (R1)
        chk(vpd == 2'b11 && vcode == '0, "R1", "reset parked", {vpd, vcode}, {2'b11, W'(0)});
        chk(srdy == 1'b1 && spor == 1'b0, "R1", "reset status", {srdy, spor}, 2'b10);

        // power-on reload and blackout length (R3, R4)
        repeat (3) step(1, 0, 0, 0, 0, 0, 0, '0, '0);
        chk(vcode == W'(F_CODE) && {vvref, vpd, vgain} == F_CFG, "R3", "por reload",
            {vvref, vpd, vgain, vcode}, {F_CFG, W'(F_CODE)});
        n = 0;
        for (int i = 0; i < 50; i++) begin
            idle(1);
            if (last_acc) break;
            n++;
        end
        chk(n == PD_LEN, "R4", "blocked cycles after por", n, PD_LEN);

        // volatile write then general-call reload (R6, R5)
        step(0, 0, 1, 0, 0, 0, 0, W'('h0F3), 5'b10100);
        chk(vcode == W'('h0F3), "R6", "vol write code", vcode, 'h0F3);
        step(0, 0, 0, 0, 0, 1, 0, '0, '0);
        chk(vcode == W'(F_CODE), "R6", "nv kept after vol write", vcode, F_CODE);
        idle(1);
        chk(last_acc == 1'b1, "R5", "no blackout after gc", last_acc, 1);

        // write-all, ack, busy window (R7, R8, R9)
        step(0, 0, 0, 1, 0, 0, 0, W'('h3C1), 5'b11011);
        step(0, 0, 0, 0, 0, 0, 1, '0, '0);
        n = 0;
        for (int i = 0; i < 50 && !srdy; i++) begin
            n++;
            if (i == 0) begin
                step(0, 0, 1, 0, 0, 0, 0, W'('h001), 5'b00000);
                chk(last_acc == 1'b0 && vcode == W'('h3C1), "R9", "busy vol write refused",
                    vcode, 'h3C1);
            end else if (i == 1) begin
                idle(1);
                chk(last_acc == 1'b1, "R9", "busy read accepted", last_acc, 1);
            end else idle(0);
        end
        chk(n == WR_LEN, "R8", "busy length", n, WR_LEN);
        step(0, 0, 1, 0, 0, 0, 0, W'('h005), 5'b00000);
        step(0, 0, 0, 0, 0, 1, 0, '0, '0);
        chk(vcode == W'('h3C1) && {vvref, vpd, vgain} == 5'b11011, "R7", "nv holds write-all",
            vcode, 'h3C1);

        // simultaneous strobes: gc wins over vol write (R12)
        step(0, 0, 1, 0, 1, 1, 0, W'('h111), 5'b00000);
        chk(vcode == W'('h3C1), "R12", "gc beats vol write", vcode, 'h3C1);

        // brown-out over power-on (R2, R1)
        step(1, 1, 0, 0, 0, 0, 0, '0, '0);
        chk(vpd == 2'b11 && vcode == '0 && !srdy, "R2", "bor wins", {vpd, vcode}, {2'b11, W'(0)});
        step(1, 0, 0, 0, 0, 0, 0, '0, '0);
        repeat (PD_LEN + 1) idle(0);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic p, b;
            p = ($urandom_range(99) < 2);
            b = ($urandom_range(99) < 2);
            step(p, b,
                 ($urandom_range(99) < 20), ($urandom_range(99) < 12),
                 ($urandom_range(99) < 15), ($urandom_range(99) < 5),
                 ($urandom_range(99) < 20),
                 W'($urandom), 5'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule